// File: doc/BRIEF.md
# Two-write two-read multiport RAM

This block is a small random-access memory that accepts two writes and serves two reads in every clock cycle. Each write port owns a full data bank with one write and one read port. A read therefore has to know which write port touched its address most recently, and a last-writer table answers that question.

The table is split into two one-bit banks, one per write port. The current owner of an address is the XOR of the two bits stored there. A write by port 0 copies port 1's bit into its own bank, which makes the XOR 0. A write by port 1 stores the inverse of port 0's bit, which makes the XOR 1. The table update runs a cycle behind the data write. In the write cycle the other bank is read back at the write address. On the next edge the port's own bank is rewritten. Later reads of the table then select the output bank. A short pending stage holds each port's table update while it is in flight. Both the feedback read and the read selection are bypassed from that stage, so back-to-back writes to one address always resolve to the newest writer.

Read data is registered and appears one cycle after the read address is presented. A read sees every write from earlier cycles. It does not see a write made to the same address in its own cycle.

Top module: `mp2w2r_ram`

## Requirements
- R1: Two writes in one cycle to different addresses are both stored, and each is returned by later reads from either read port.
- R2: The two read ports are independent. The data for the address presented on `ra0`/`ra1` in one cycle appears on `rd0`/`rd1` after the next rising edge.
- R3: When both write ports write the same address in the same cycle, the value from write port 1 is the one stored.
- R4: A write by port 0 followed in the next cycle by a write by port 1 to the same address leaves port 1's value, even though the first table update is still in flight.
- R5: A write by port 1 followed in the next cycle by a write by port 0 to the same address leaves port 0's value.
- R6: A read of an address that is written in the same cycle returns the value held before that write.
- R7: A read in the cycle right after a write to its address returns the new value, with no extra wait for the table update.
- R8: While `rst` is high at a rising edge, `rd0` and `rd1` become 0 and writes are ignored. Stored contents from before the reset remain readable afterwards.
- R9: With `we0` or `we1` low, that port's address and data have no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst | input | 1 | Synchronous reset of the pending stage and read outputs, active high |
| we0 | input | 1 | Write enable of write port 0 |
| wa0 | input | AW | Write address of write port 0 |
| wd0 | input | DW | Write data of write port 0 |
| we1 | input | 1 | Write enable of write port 1 (wins a same-address tie) |
| wa1 | input | AW | Write address of write port 1 |
| wd1 | input | DW | Write data of write port 1 |
| ra0 | input | AW | Read address of read port 0 |
| rd0 | output | DW | Registered read data of read port 0 |
| ra1 | input | AW | Read address of read port 1 |
| rd1 | output | DW | Registered read data of read port 1 |

## Verification
The hardest case to reach from the ports is a table bit that is still in the pending stage while a second write or a read needs it. This happens when ownership of an address changes in two consecutive cycles and a read follows at once. Directed vectors build exactly that: a port 0 write followed by a port 1 write to the same address, then the reverse order, and same-cycle collisions, each with a read on the following cycle. Long runs of random traffic over only sixteen addresses then keep both ports colliding and handing ownership back and forth, and every read is compared against a plain reference array.

// File: rtl/mp2w2r_ram.sv
module mp2w2r_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1
);

  logic [DW-1:0]    bank0 [DEPTH];
  logic [DW-1:0]    bank1 [DEPTH];
  logic [DEPTH-1:0] tbl0 = '0;
  logic [DEPTH-1:0] tbl1 = '0;

  logic          p0_v, p1_v;
  logic [AW-1:0] p0_a, p1_a;
  logic          p0_b, p1_b;

  function automatic logic look(input logic [DEPTH-1:0] t, input logic pv,
                                input logic [AW-1:0] pa, input logic pb,
                                input logic [AW-1:0] a);
    return (pv && pa == a) ? pb : t[a];
  endfunction

  wire wen0 = we0 & ~rst;
  wire wen1 = we1 & ~rst;

  wire fb0 = look(tbl1, p1_v, p1_a, p1_b, wa0);
  wire fb1 = (wen0 && wa0 == wa1) ? fb0 : look(tbl0, p0_v, p0_a, p0_b, wa1);

  wire sel0 = look(tbl0, p0_v, p0_a, p0_b, ra0) ^ look(tbl1, p1_v, p1_a, p1_b, ra0);
  wire sel1 = look(tbl0, p0_v, p0_a, p0_b, ra1) ^ look(tbl1, p1_v, p1_a, p1_b, ra1);

  always_ff @(posedge clk) begin
    if (wen0) bank0[wa0] <= wd0;
    if (wen1) bank1[wa1] <= wd1;
    if (p0_v) tbl0[p0_a] <= p0_b;
    if (p1_v) tbl1[p1_a] <= p1_b;
    p0_v <= wen0;
    p0_a <= wa0;
    p0_b <= fb0;
    p1_v <= wen1;
    p1_a <= wa1;
    p1_b <= ~fb1;
    if (rst) begin
      rd0 <= '0;
      rd1 <= '0;
    end else begin
      rd0 <= sel0 ? bank1[ra0] : bank0[ra0];
      rd1 <= sel1 ? bank1[ra1] : bank0[ra1];
    end
  end

endmodule

module mp2w2r_ram_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          we0,
  input logic [AW-1:0] wa0,
  input logic [DW-1:0] wd0,
  input logic          we1,
  input logic [AW-1:0] wa1,
  input logic [DW-1:0] wd1,
  input logic [AW-1:0] ra0,
  input logic [DW-1:0] rd0,
  input logic [AW-1:0] ra1,
  input logic [DW-1:0] rd1
);

  AST_RESET_CLEARS_OUT: assert property (@(posedge clk)
    rst |=> (rd0 == '0 && rd1 == '0)); // R8

  AST_PORT1_NEWEST: assert property (@(posedge clk) disable iff (rst)
    ($past(we1 & ~rst) && $past(wa1) == ra0) |=> rd0 == $past(wd1, 2)); // R4

  AST_PORT0_NEWEST: assert property (@(posedge clk) disable iff (rst)
    ($past(we0 & ~rst) && $past(wa0) == ra1 &&
     !($past(we1) && $past(wa1) == $past(wa0))) |=> rd1 == $past(wd0, 2)); // R5

  AST_IDLE_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ra0 == $past(ra0) && !$past(we0) && !$past(we1)) |=> $stable(rd0)); // R9

endmodule

bind mp2w2r_ram mp2w2r_ram_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .we0(we0), .wa0(wa0), .wd0(wd0),
  .we1(we1), .wa1(wa1), .wd1(wd1),
  .ra0(ra0), .rd0(rd0), .ra1(ra1), .rd1(rd1)
);

// File: tb/tb_mp2w2r_ram.sv
module tb_mp2w2r_ram;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [AW-1:0] wa0 = '0, wa1 = '0, ra0 = '0, ra1 = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic [DW-1:0] rd0, rd1;

  always #5 clk = ~clk;

  mp2w2r_ram #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .we0(we0), .wa0(wa0), .wd0(wd0),
    .we1(we1), .wa1(wa1), .wd1(wd1),
    .ra0(ra0), .rd0(rd0), .ra1(ra1), .rd1(rd1)
  );

  typedef struct packed {
    logic          w0;
    logic [AW-1:0] a0;
    logic [DW-1:0] d0;
    logic          w1;
    logic [AW-1:0] a1;
    logic [DW-1:0] d1;
    logic [AW-1:0] r0;
    logic [AW-1:0] r1;
    logic [3:0]    req;
  } vec_t;

  // Tags: R6 same-cycle old value, R7 next-cycle new value, R3 collision,
  // R2 independent reads, R4 port0-then-port1, R5 port1-then-port0, R9 disabled writes.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd3, 8'hA1, 1'b1, 4'd5, 8'hB1, 4'd3, 4'd5, 4'd6},
    '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00, 4'd3, 4'd5, 4'd7},
    '{1'b1, 4'd7, 8'hC3, 1'b1, 4'd7, 8'hD3, 4'd7, 4'd7, 4'd6},
    '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00, 4'd7, 4'd2, 4'd3},
    '{1'b1, 4'd9, 8'h11, 1'b0, 4'd0, 8'h00, 4'd9, 4'd9, 4'd2},
    '{1'b0, 4'd0, 8'h00, 1'b1, 4'd9, 8'h22, 4'd9, 4'd1, 4'd4},
    '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00, 4'd9, 4'd9, 4'd4},
    '{1'b0, 4'd0, 8'h00, 1'b1, 4'd10, 8'h33, 4'd10, 4'd0, 4'd5},
    '{1'b1, 4'd10, 8'h44, 1'b0, 4'd0, 8'h00, 4'd10, 4'd10, 4'd5},
    '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00, 4'd10, 4'd10, 4'd5},
    '{1'b1, 4'd12, 8'h55, 1'b1, 4'd13, 8'h66, 4'd12, 4'd13, 4'd1},
    '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00, 4'd13, 4'd12, 4'd1},
    '{1'b0, 4'd10, 8'hFF, 1'b0, 4'd10, 8'hEE, 4'd10, 4'd10, 4'd9},
    '{1'b0, 4'd0, 8'h00, 1'b0, 4'd0, 8'h00, 4'd10, 4'd0, 4'd9}
  };

  logic [DW-1:0] mem [DEPTH];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle (called right after a falling edge), check the reads at the next falling edge.
  task automatic step(input logic w0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                      input logic w1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                      input logic [AW-1:0] r0, input logic [AW-1:0] r1, input int req);
    logic [DW-1:0] e0, e1;
    we0 = w0; wa0 = a0; wd0 = d0;
    we1 = w1; wa1 = a1; wd1 = d1;
    ra0 = r0; ra1 = r1;
    e0 = mem[r0];
    e1 = mem[r1];
    if (w0) mem[a0] = d0;
    if (w1) mem[a1] = d1;
    @(negedge clk);
    if (req != 0) begin
      check(rd0, e0, req);
      check(rd1, e1, req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R8: reset value of the read outputs
    check(rd0, '0, 8);
    check(rd1, '0, 8);
    rst = 1'b0;

    for (int a = 0; a < DEPTH; a += 2)
      step(1'b1, AW'(a), DW'(a * 3 + 1), 1'b1, AW'(a + 1), DW'(a * 5 + 2), '0, '0, 0);

    for (int a = 0; a < DEPTH; a += 2)
      step(1'b0, '0, '0, 1'b0, '0, '0, AW'(a), AW'(a + 1), 1); // R1

    for (int i = 0; i < NV; i++)
      step(VEC[i].w0, VEC[i].a0, VEC[i].d0, VEC[i].w1, VEC[i].a1, VEC[i].d1,
           VEC[i].r0, VEC[i].r1, int'(VEC[i].req));

    // R4 chain: port 0 then port 1 on one address, read on the very next cycle
    step(1'b1, 4'd6, 8'h71, 1'b0, '0, '0, 4'd6, 4'd6, 4);
    step(1'b0, '0, '0, 1'b1, 4'd6, 8'h72, 4'd6, 4'd6, 4);
    step(1'b0, '0, '0, 1'b0, '0, '0, 4'd6, 4'd6, 4);
    // R5 chain: port 1 then port 0, then port 1 again, alternating ownership
    step(1'b0, '0, '0, 1'b1, 4'd8, 8'h81, 4'd8, 4'd6, 5);
    step(1'b1, 4'd8, 8'h82, 1'b0, '0, '0, 4'd8, 4'd8, 5);
    step(1'b0, '0, '0, 1'b1, 4'd8, 8'h83, 4'd8, 4'd8, 5);
    step(1'b1, 4'd8, 8'h84, 1'b1, 4'd8, 8'h85, 4'd8, 4'd8, 3);
    step(1'b0, '0, '0, 1'b0, '0, '0, 4'd8, 4'd8, 3);

    // R1/R2: random traffic over a small address space
    for (int i = 0; i < 4000; i++)
      step(1'($urandom), AW'($urandom), DW'($urandom),
           1'($urandom), AW'($urandom), DW'($urandom),
           AW'($urandom), AW'($urandom), 2);

    // R8: reset with writes requested; writes ignored, outputs cleared, contents kept
    step(1'b0, '0, '0, 1'b0, '0, '0, 4'd1, 4'd2, 2);
    rst = 1'b1;
    we0 = 1'b1; wa0 = 4'd1; wd0 = 8'h5A;
    we1 = 1'b1; wa1 = 4'd2; wd1 = 8'hA5;
    @(negedge clk);
    check(rd0, '0, 8);
    check(rd1, '0, 8);
    rst = 1'b0;
    step(1'b0, '0, '0, 1'b0, '0, '0, 4'd1, 4'd2, 8);
    step(1'b0, '0, '0, 1'b0, '0, '0, 4'd1, 4'd2, 8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule